// File: doc/BRIEF.md
# Register-Pair Bit Shuffle Unit

This unit takes two 32-bit register values and treats them as a single 64-bit word, with the first register holding the upper half. It applies one of a few bit-rearranging operations to that word and hands back the two updated register values. The operations are a population count of the whole word, a spread that turns eight bits into eight byte-wide flags, and a transpose of the word viewed as an 8 by 8 bit matrix. A fourth select code passes the pair through unchanged.

A caller presents both register values and an operation code together with a one-cycle start strobe. On the next clock edge the unit captures the result into its output registers and raises a valid strobe for one cycle. The outputs then hold their value until the next start. Bytes are numbered 0 to 7 from the top of the pair: byte 0 is `src_hi[31:24]` and byte 7 is `src_lo[7:0]`.

Top module: `pair_shuffle`

## Requirements
- R1: While reset is asserted (`rst_n` low), both result outputs read zero and `done` is low.
- R2: `done` is high in the cycle after a cycle in which `start` was high, and low in the cycle after a cycle in which `start` was low.
- R3: When `start` is low, the result outputs keep their values at the next edge, no matter how `op`, `src_hi` or `src_lo` change.
- R4: With `op` = 2'b00 (count), `res_lo` becomes the number of 1 bits across all 64 bits of `{src_hi, src_lo}`, a value from 0 to 64 stored zero-extended.
- R5: With `op` = 2'b00, `res_hi` becomes a copy of `src_hi`.
- R6: With `op` = 2'b01 (spread), byte k of `{res_hi, res_lo}` becomes 8'h01 if bit (7-k) of `src_lo` is 1 and 8'h00 if it is 0. Byte k is `{res_hi,res_lo}[63-8k -: 8]`, so the most significant bit of `src_lo[7:0]` controls byte 0.
- R7: With `op` = 2'b10 (transpose), byte r of the pair is row r and bit (7-c) of that byte is column c. The output element at row r, column c equals the input element at row c, column r. Doing the transpose twice returns the original word.
- R8: With `op` = 2'b11 (pass), `res_hi` and `res_lo` become copies of `src_hi` and `src_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture strobe for one operation |
| op | input | 2 | Operation code: 00 count, 01 spread, 10 transpose, 11 pass |
| src_hi | input | 32 | First register value, upper half of the pair |
| src_lo | input | 32 | Second register value, lower half of the pair |
| res_hi | output | 32 | Updated first register |
| res_lo | output | 32 | Updated second register |
| done | output | 1 | Result valid, high for one cycle after start |

## Verification
The boundary cases are the hardest to reach with random operands. A count of exactly 0 or exactly 64 needs an all-zero or all-ones pair, and a transpose fault only shows up when the matrix is not symmetric about its diagonal. Random 64-bit words almost never produce these patterns. The stimulus therefore adds directed pairs: all zeros, all ones, a single set bit in a corner cell, and words with one row filled. It also checks the hold behaviour by changing every input while `start` stays low and confirming that the outputs do not move.

// File: rtl/pair_shuffle.sv
module pair_shuffle #(
  parameter int HALF_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [HALF_W-1:0] src_hi,
  input  logic [HALF_W-1:0] src_lo,
  output logic [HALF_W-1:0] res_hi,
  output logic [HALF_W-1:0] res_lo,
  output logic              done
);
  localparam int PAIR_W = 2 * HALF_W;
  localparam int LANES  = PAIR_W / LANE_W;
  localparam int CNT_W  = $clog2(PAIR_W + 1);
  localparam logic [1:0] OP_CNT = 2'b00;
  localparam logic [1:0] OP_SPR = 2'b01;
  localparam logic [1:0] OP_TRN = 2'b10;

  logic [PAIR_W-1:0] pair_in, spread_w, trans_w, next_w;
  logic [CNT_W-1:0]  ones;

  assign pair_in = {src_hi, src_lo};

  always_comb begin
    ones = '0;
    for (int i = 0; i < PAIR_W; i++) ones = ones + CNT_W'(pair_in[i]);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_spread
    assign spread_w[PAIR_W-1-LANE_W*k -: LANE_W] = {{(LANE_W-1){1'b0}}, src_lo[LANE_W-1-k]};
  end

  for (genvar r = 0; r < LANES; r++) begin : g_row
    for (genvar c = 0; c < LANE_W; c++) begin : g_col
      assign trans_w[PAIR_W-1-LANE_W*r-c] = pair_in[PAIR_W-1-LANE_W*c-r];
    end
  end

  always_comb begin
    case (op)
      OP_CNT:  next_w = {src_hi, {(HALF_W-CNT_W){1'b0}}, ones};
      OP_SPR:  next_w = spread_w;
      OP_TRN:  next_w = trans_w;
      default: next_w = pair_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi <= '0;
      res_lo <= '0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start) {res_hi, res_lo} <= next_w;
    end
  end

  assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable({res_hi, res_lo}));
  assert_count_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_CNT) |=> (res_lo == HALF_W'($countones($past(pair_in)))));
  assert_count_keeps_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_CNT) |=> (res_hi == $past(src_hi)));
  assert_spread_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_SPR) |=> ($countones({res_hi, res_lo}) == $countones($past(src_lo[LANE_W-1:0]))));
  assert_transpose_weight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_TRN) |=> ($countones({res_hi, res_lo}) == $countones($past(pair_in))));
  assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'b11) |=> ({res_hi, res_lo} == $past(pair_in)));
endmodule

// File: tb/tb_pair_shuffle.sv
module tb_pair_shuffle;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] src_hi = '0, src_lo = '0;
  logic [31:0] res_hi, res_lo;
  logic        done;
  int checks = 0, errors = 0;
  bit finished = 0;

  pair_shuffle dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_hi(src_hi), .src_lo(src_lo), .res_hi(res_hi), .res_lo(res_lo), .done(done));

  always #5 clk = ~clk;

  function automatic logic [63:0] exp_count(input logic [63:0] w);
    int n = 0;
    for (int i = 0; i < 64; i++) if (w[i]) n++;
    return {w[63:32], 32'(n)};
  endfunction

  function automatic logic [63:0] exp_spread(input logic [63:0] w);
    logic [63:0] o = '0;
    for (int k = 0; k < 8; k++) o[63-8*k -: 8] = w[7-k] ? 8'h01 : 8'h00;
    return o;
  endfunction

  function automatic logic [63:0] exp_trans(input logic [63:0] w);
    logic [7:0] m [8];
    logic [63:0] o = '0;
    for (int r = 0; r < 8; r++) m[r] = w[63-8*r -: 8];
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) o[63-8*r-c] = m[c][7-r];
    return o;
  endfunction

  function automatic logic [63:0] expect_of(input logic [1:0] o, input logic [63:0] w);
    case (o)
      2'b00: return exp_count(w);
      2'b01: return exp_spread(w);
      2'b10: return exp_trans(w);
      default: return w;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [63:0] w, input string req);
    @(negedge clk);
    op = o; {src_hi, src_lo} = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 done", {63'd0, done}, 64'd1);
    check(req, {res_hi, res_lo}, expect_of(o, w));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] held, w, t;
    void'($urandom(32'h5eed_1234));
    #12;
    check("R1 reset outputs", {res_hi, res_lo}, 64'd0);
    check("R1 reset done", {63'd0, done}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    run_op(2'b00, 64'd0, "R4 count zero");
    run_op(2'b00, '1, "R4 count all ones");
    run_op(2'b00, 64'h8000_0000_0000_0001, "R4 R5 count corners");
    run_op(2'b00, 64'hDEAD_BEEF_0000_0000, "R5 count keeps hi");
    run_op(2'b01, 64'h1234_5678_9ABC_DE80, "R6 spread msb");
    run_op(2'b01, 64'hFFFF_FFFF_FFFF_FF01, "R6 spread lsb");
    run_op(2'b01, 64'h0000_0000_0000_00FF, "R6 spread all");
    run_op(2'b10, 64'h8000_0000_0000_0000, "R7 transpose corner");
    run_op(2'b10, 64'hFF00_0000_0000_0000, "R7 transpose row");
    run_op(2'b10, 64'h0102_0408_1020_4080, "R7 transpose anti diag");
    run_op(2'b11, 64'hCAFE_F00D_1234_5678, "R8 pass");

    w = 64'h0123_4567_89AB_CDEF;
    run_op(2'b10, w, "R7 transpose first");
    t = {res_hi, res_lo};
    run_op(2'b10, t, "R7 transpose second");
    check("R7 double transpose", {res_hi, res_lo}, w);

    held = {res_hi, res_lo};
    @(negedge clk);
    op = 2'b01; src_hi = ~src_hi; src_lo = 32'h0000_00A5;
    @(negedge clk);
    check("R2 no start done", {63'd0, done}, 64'd0);
    check("R3 hold", {res_hi, res_lo}, held);
    op = 2'b00; src_hi = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R3 hold again", {res_hi, res_lo}, held);

    for (int i = 0; i < 200; i++) begin
      logic [1:0] o;
      o = 2'($urandom_range(0, 3));
      w = {$urandom(), $urandom()};
      case (o)
        2'b00: run_op(o, w, "R4 R5 random count");
        2'b01: run_op(o, w, "R6 random spread");
        2'b10: run_op(o, w, "R7 random transpose");
        default: run_op(o, w, "R8 random pass");
      endcase
    end
    finish_run();
  end
endmodule